// File: doc/BRIEF.md
# Multi-Domain Reset Controller

This block produces one active-high reset for each of three power domains: a battery-backed retained domain, a standby domain and a main domain. Its inputs are three digitized supply-good indications (high while a supply is not yet valid), an active-low hardware reset pin and two software reset request bits. One request bit is written by the host and the other by the management controller. Each domain reset is the OR of its own set of sources. The reset asserts at once when any source rises. It deasserts only after two edges of the 32 kHz clock once every source has gone low. All three domains share that clock as their timebase.

The standby power-up sequence is timed by a counter on the 32 kHz clock, and its length depends on conditions. The full length is 8192 counted cycles. The sequence is shortened to 1280 counted cycles when the synchronized hardware reset goes high early. It is lengthened by a configurable settle wait when the oscillator was off before power-up. While the sequence runs, the block holds the strap pins tristated with pull-downs enabled, keeps the management bus from responding, and holds the main domain in reset. When the sequence ends, the block captures the strap levels and issues a one-cycle sample strobe.

Top module: `domain_reset_ctl`

## Requirements
- R1: `rst_ret` is high while `por_ret` is high. It is driven by nothing else: the hardware pin, both software requests and the other supply indications leave it unchanged.
- R2: `rst_sby` is high while `por_sby` is high, while the standby sequence runs, or during a controller request pulse. Host requests and the hardware pin do not affect it.
- R3: `rst_main` is high while `por_main` is high, while `hw_rst_n` is low, during a host request pulse, and for the whole standby sequence even when main power is good. Controller requests do not affect it.
- R4: After `por_sby` falls, with `osc_was_off` low and no early release, the sequence lasts 1 + FULL_LEN clock cycles (8193 by default). Cycles are counted from the falling edge of `por_sby` until `mbus_hold` goes low.
- R5: The sequence lasts 1 + SHORT_LEN cycles (1281 by default) when the two-flop-synchronized `hw_rst_n` is high at some counted cycle whose count is below SHORT_LEN. A release that comes later leaves the full length in force.
- R6: `osc_was_off` is sampled in the first cycle after `por_sby` falls. When it is high, SETTLE_LEN cycles (1024 by default) are added ahead of the count.
- R7: `strap_hiz` is high for exactly the cycles of the sequence. `strap_q` takes the `strap_pins` value present at the last sequence edge. `strap_sample` is high for the single cycle that follows that edge. After that, changes on `strap_pins` leave `strap_q` unchanged.
- R8: `mbus_hold` is high for the whole sequence and falls in the same cycle that `strap_sample` rises.
- R9: A rising edge on `host_sw_req` or `ctrl_sw_req` starts a pulse of SW_PULSE_LEN cycles. Its domain reset is high for SW_PULSE_LEN + 2 cycles (6 by default). A request held high does not start a second pulse.
- R10: Each domain reset rises without waiting for a clock edge when a source rises. It falls at the second rising clock edge after all of its sources are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | 32 kHz clock, the timebase of all domains |
| por_ret | input | 1 | Retained supply not yet valid (high = reset) |
| por_sby | input | 1 | Standby supply not yet valid (high = reset) |
| por_main | input | 1 | Main supply not yet valid (high = reset) |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| host_sw_req | input | 1 | Host software reset request bit |
| ctrl_sw_req | input | 1 | Controller software reset request bit |
| osc_was_off | input | 1 | Oscillator was disabled before standby power-up |
| strap_pins | input | STRAP_W | Strap pin levels |
| rst_ret | output | 1 | Retained domain reset, active high |
| rst_sby | output | 1 | Standby domain reset, active high |
| rst_main | output | 1 | Main domain reset, active high |
| strap_hiz | output | 1 | Strap pins tristated with pull-downs on |
| strap_sample | output | 1 | One-cycle strobe marking strap capture |
| strap_q | output | STRAP_W | Captured strap levels |
| mbus_hold | output | 1 | Management bus held non-responsive |

## Verification
The assertions assume that the supply indications and the request bits change only away from the rising clock edge. They also assume that `por_sby` starts high, so that every property is disabled until the first standby power-up. The bench drives all inputs at falling edges, with one exception: the hardware pin is dropped mid-cycle to exercise immediate assertion, and no property samples it on that edge. The bench clears each request bit once it sees the reset that the request caused, except in the case that deliberately holds a request high.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    SEQ_ARM    = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_COUNT  = 2'd2,
    SEQ_DONE   = 2'd3
  } seq_state_e;

  // Last count value of the standby sequence for the selected length.
  function automatic int unsigned seq_last(input logic short_hit,
                                           input int unsigned full_len,
                                           input int unsigned short_len);
    return (short_hit ? short_len : full_len) - 1;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drc_bitsync.sv
// Plain multi-flop synchronizer for a level input; clears to zero.
module drc_bitsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh <= '0;
    else      sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/drc_rsync.sv
// Reset stretcher: immediate set, release after STAGES clean edges.
module drc_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic src,
  output logic rst_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge src) begin
    if (src) sh <= '1;
    else     sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_out = sh[STAGES-1];
endmodule

// File: rtl/drc_swpulse.sv
// Turns the rising edge of a request bit into a fixed-length pulse.
module drc_swpulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic pwr_rst,
  input  logic req,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic          req_prev;
  logic [CW-1:0] left;
  logic          req_rise;

  assign req_rise = req & ~req_prev;

  always_ff @(posedge clk or posedge pwr_rst) begin
    if (pwr_rst) begin
      req_prev <= 1'b0;
      left     <= '0;
    end else begin
      req_prev <= req;
      if (req_rise)          left <= LEN_C;
      else if (left != '0)   left <= left - 1'b1;
    end
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/drc_sby_timer.sv
// Standby power-up sequencer: optional settle wait, then a count whose
// length depends on whether the hardware pin was released early.
module drc_sby_timer
  import drc_pkg::*;
#(
  parameter int FULL_LEN   = 8192,
  parameter int SHORT_LEN  = 1280,
  parameter int SETTLE_LEN = 1024,
  parameter int STRAP_W    = 4
) (
  input  logic               clk,
  input  logic               por_sby,
  input  logic               osc_was_off,
  input  logic               hw_ok,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic               seq_active,
  output logic               short_hit,
  output logic               strap_sample,
  output logic [STRAP_W-1:0] strap_q
);
  localparam int CW = $clog2(max_of(FULL_LEN, SETTLE_LEN) + 1);
  localparam logic [CW-1:0] SHORT_C      = CW'(SHORT_LEN);
  localparam logic [CW-1:0] SETTLE_LAST  = CW'(SETTLE_LEN - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          short_q;
  logic          count_end;
  logic          settle_end;

  always_comb begin
    short_hit  = short_q | ((state == SEQ_COUNT) && hw_ok && (cnt < SHORT_C));
    count_end  = (state == SEQ_COUNT) &&
                 (cnt == CW'(seq_last(short_hit, FULL_LEN, SHORT_LEN)));
    settle_end = (state == SEQ_SETTLE) && (cnt == SETTLE_LAST);
  end

  always_ff @(posedge clk or posedge por_sby) begin
    if (por_sby) begin
      state        <= SEQ_ARM;
      cnt          <= '0;
      short_q      <= 1'b0;
      strap_sample <= 1'b0;
      strap_q      <= '0;
    end else begin
      strap_sample <= 1'b0;
      unique case (state)
        SEQ_ARM: begin
          cnt   <= '0;
          state <= osc_was_off ? SEQ_SETTLE : SEQ_COUNT;
        end
        SEQ_SETTLE: begin
          if (settle_end) begin
            cnt   <= '0;
            state <= SEQ_COUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_COUNT: begin
          short_q <= short_hit;
          if (count_end) begin
            state        <= SEQ_DONE;
            strap_sample <= 1'b1;
            strap_q      <= strap_pins;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_DONE;
      endcase
    end
  end

  assign seq_active = (state != SEQ_DONE);
endmodule

// File: rtl/domain_reset_ctl.sv
module domain_reset_ctl #(
  parameter int FULL_LEN     = 8192,
  parameter int SHORT_LEN    = 1280,
  parameter int SETTLE_LEN   = 1024,
  parameter int SW_PULSE_LEN = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int STRAP_W      = 4
) (
  input  logic               clk_lf,
  input  logic               por_ret,
  input  logic               por_sby,
  input  logic               por_main,
  input  logic               hw_rst_n,
  input  logic               host_sw_req,
  input  logic               ctrl_sw_req,
  input  logic               osc_was_off,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic               rst_ret,
  output logic               rst_sby,
  output logic               rst_main,
  output logic               strap_hiz,
  output logic               strap_sample,
  output logic [STRAP_W-1:0] strap_q,
  output logic               mbus_hold
);
  localparam int N_DOM   = 3;
  localparam int DOM_RET = 0;
  localparam int DOM_SBY = 1;
  localparam int DOM_MAIN = 2;

  // Internal events brought out for the checker.
  logic hw_ok;
  logic seq_active;
  logic short_hit;
  logic host_pulse;
  logic ctrl_pulse;
  logic [N_DOM-1:0] dom_src;
  logic [N_DOM-1:0] dom_rst;

  drc_bitsync #(.STAGES(SYNC_STAGES)) i_hw_sync (
    .clk (clk_lf),
    .arst(por_sby),
    .d   (hw_rst_n),
    .q   (hw_ok)
  );

  drc_sby_timer #(
    .FULL_LEN  (FULL_LEN),
    .SHORT_LEN (SHORT_LEN),
    .SETTLE_LEN(SETTLE_LEN),
    .STRAP_W   (STRAP_W)
  ) i_timer (
    .clk         (clk_lf),
    .por_sby     (por_sby),
    .osc_was_off (osc_was_off),
    .hw_ok       (hw_ok),
    .strap_pins  (strap_pins),
    .seq_active  (seq_active),
    .short_hit   (short_hit),
    .strap_sample(strap_sample),
    .strap_q     (strap_q)
  );

  drc_swpulse #(.LEN(SW_PULSE_LEN)) i_host_pulse (
    .clk    (clk_lf),
    .pwr_rst(por_main),
    .req    (host_sw_req),
    .pulse  (host_pulse)
  );

  drc_swpulse #(.LEN(SW_PULSE_LEN)) i_ctrl_pulse (
    .clk    (clk_lf),
    .pwr_rst(por_sby),
    .req    (ctrl_sw_req),
    .pulse  (ctrl_pulse)
  );

  // Per-domain OR of reset sources.
  assign dom_src[DOM_RET]  = por_ret;
  assign dom_src[DOM_SBY]  = por_sby | seq_active | ctrl_pulse;
  assign dom_src[DOM_MAIN] = por_main | ~hw_rst_n | host_pulse | seq_active;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    drc_rsync #(.STAGES(SYNC_STAGES)) i_rsync (
      .clk    (clk_lf),
      .src    (dom_src[d]),
      .rst_out(dom_rst[d])
    );
  end

  assign rst_ret   = dom_rst[DOM_RET];
  assign rst_sby   = dom_rst[DOM_SBY];
  assign rst_main  = dom_rst[DOM_MAIN];
  assign strap_hiz = seq_active;
  assign mbus_hold = seq_active;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
  parameter int FULL_LEN   = 8192,
  parameter int SETTLE_LEN = 1024,
  parameter int STRAP_W    = 4
) (
  input logic               clk_lf,
  input logic               por_ret,
  input logic               por_sby,
  input logic               por_main,
  input logic               hw_rst_n,
  input logic               seq_active,
  input logic               short_hit,
  input logic               host_pulse,
  input logic               ctrl_pulse,
  input logic               rst_ret,
  input logic               rst_sby,
  input logic               rst_main,
  input logic               mbus_hold,
  input logic               strap_sample,
  input logic [STRAP_W-1:0] strap_q
);
  localparam int unsigned SEQ_BOUND = 1 + SETTLE_LEN + FULL_LEN;

  int unsigned act_cnt;

  always_ff @(posedge clk_lf or posedge por_sby) begin
    if (por_sby)         act_cnt <= 0;
    else if (seq_active) act_cnt <= act_cnt + 1;
  end

  assert_ret_follows_por_R1: assert property (@(posedge clk_lf)
    disable iff (por_sby) por_ret |-> rst_ret);

  assert_ret_quiet_R1: assert property (@(posedge clk_lf)
    disable iff (por_ret) (!$past(por_ret) && !$past(por_ret, 2)) |-> !rst_ret);

  assert_sby_in_seq_R2: assert property (@(posedge clk_lf)
    disable iff (por_sby) seq_active |-> rst_sby);

  assert_main_in_seq_R3: assert property (@(posedge clk_lf)
    disable iff (por_sby) seq_active |-> rst_main);

  assert_main_on_pin_R3: assert property (@(posedge clk_lf)
    disable iff (por_sby) (!hw_rst_n || por_main) |-> rst_main);

  assert_seq_bounded_R4: assert property (@(posedge clk_lf)
    disable iff (por_sby) act_cnt <= SEQ_BOUND);

  assert_short_sticky_R5: assert property (@(posedge clk_lf)
    disable iff (por_sby) (short_hit && seq_active) |=> (short_hit || !seq_active));

  assert_strap_hold_R7: assert property (@(posedge clk_lf)
    disable iff (por_sby) !strap_sample |-> $stable(strap_q));

  assert_bus_release_R8: assert property (@(posedge clk_lf)
    disable iff (por_sby) $fell(mbus_hold) |-> strap_sample);

  assert_ctrl_pulse_R9: assert property (@(posedge clk_lf)
    disable iff (por_sby) ctrl_pulse |-> rst_sby);

  assert_host_pulse_R9: assert property (@(posedge clk_lf)
    disable iff (por_sby) host_pulse |-> rst_main);
endmodule

bind domain_reset_ctl drc_chk #(
  .FULL_LEN  (FULL_LEN),
  .SETTLE_LEN(SETTLE_LEN),
  .STRAP_W   (STRAP_W)
) i_chk (
  .clk_lf      (clk_lf),
  .por_ret     (por_ret),
  .por_sby     (por_sby),
  .por_main    (por_main),
  .hw_rst_n    (hw_rst_n),
  .seq_active  (seq_active),
  .short_hit   (short_hit),
  .host_pulse  (host_pulse),
  .ctrl_pulse  (ctrl_pulse),
  .rst_ret     (rst_ret),
  .rst_sby     (rst_sby),
  .rst_main    (rst_main),
  .mbus_hold   (mbus_hold),
  .strap_sample(strap_sample),
  .strap_q     (strap_q)
);

// File: tb/test_domain_reset_ctl.sv
module test_domain_reset_ctl;
  localparam int CLK_T   = 10;
  localparam int FULL    = 8192;
  localparam int SHORT   = 1280;
  localparam int SETTLE  = 1024;
  localparam int PULSE   = 4;
  localparam int SW      = 4;
  localparam int NV      = 4;

  // Sequence table: oscillator flag, negedge index of pin release, strap pattern, length.
  localparam int V_OSC [NV] = '{0, 1, 0, 1};
  localparam int V_HW  [NV] = '{200, 3000, 3000, 200};
  localparam int V_PAT [NV] = '{5, 10, 3, 12};
  localparam int V_LEN [NV] = '{1 + SHORT, 1 + SETTLE + FULL, 1 + FULL, 1 + SETTLE + SHORT};

  logic          clk_lf = 1'b0;
  logic          por_ret = 1'b1, por_sby = 1'b1, por_main = 1'b1;
  logic          hw_rst_n = 1'b0, host_sw_req = 1'b0, ctrl_sw_req = 1'b0;
  logic          osc_was_off = 1'b0;
  logic [SW-1:0] strap_pins = '0;
  logic          rst_ret, rst_sby, rst_main, strap_hiz, strap_sample, mbus_hold;
  logic [SW-1:0] strap_q;

  int errors = 0;
  int checks = 0;

  always #(CLK_T/2) clk_lf = ~clk_lf;

  domain_reset_ctl #(
    .FULL_LEN(FULL), .SHORT_LEN(SHORT), .SETTLE_LEN(SETTLE),
    .SW_PULSE_LEN(PULSE), .SYNC_STAGES(2), .STRAP_W(SW)
  ) i_domain_reset_ctl (
    .clk_lf(clk_lf), .por_ret(por_ret), .por_sby(por_sby), .por_main(por_main),
    .hw_rst_n(hw_rst_n), .host_sw_req(host_sw_req), .ctrl_sw_req(ctrl_sw_req),
    .osc_was_off(osc_was_off), .strap_pins(strap_pins),
    .rst_ret(rst_ret), .rst_sby(rst_sby), .rst_main(rst_main),
    .strap_hiz(strap_hiz), .strap_sample(strap_sample), .strap_q(strap_q),
    .mbus_hold(mbus_hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_lf);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_seq(input int v);
    int n = 0;
    int hiz_bad = 0;
    int main_mid = 0;
    por_sby     = 1'b1;
    hw_rst_n    = 1'b0;
    osc_was_off = (V_OSC[v] != 0);
    strap_pins  = SW'(V_PAT[v]);
    negs(2);
    por_sby = 1'b0;
    while (mbus_hold && n < 20000) begin
      n++;
      if (!strap_hiz) hiz_bad++;
      if (n == 500) main_mid = (rst_main && rst_sby) ? 1 : 0;
      if (n == V_HW[v]) hw_rst_n = 1'b1;
      @(negedge clk_lf);
    end
    chk("R4/R5/R6 sequence length", n, V_LEN[v]);
    chk("R7 hiz low at end", int'(strap_hiz), 0);
    chk("R7 hiz through sequence", hiz_bad, 0);
    chk("R3 main held mid sequence", main_mid, 1);
    chk("R8 strobe with bus release", int'(strap_sample), 1);
    chk("R7 strap captured", int'(strap_q), V_PAT[v]);
    strap_pins = ~SW'(V_PAT[v]);
    negs(1);
    chk("R7 strobe single cycle", int'(strap_sample), 0);
    negs(2);
    chk("R7 strap unchanged later", int'(strap_q), V_PAT[v]);
    chk("R2 standby released", int'(rst_sby), 0);
    chk("R3 main released", int'(rst_main), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_lf);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    int other;
    negs(3);
    chk("R1 reset state ret", int'(rst_ret), 1);
    chk("R2 reset state sby", int'(rst_sby), 1);
    chk("R3 reset state main", int'(rst_main), 1);
    chk("R8 reset state bus", int'(mbus_hold), 1);
    chk("R7 reset state hiz", int'(strap_hiz), 1);

    // R10: release after two rising edges.
    por_ret = 1'b0;
    por_main = 1'b0;
    negs(1);
    chk("R10 ret still high one edge", int'(rst_ret), 1);
    negs(1);
    chk("R10 ret low after two edges", int'(rst_ret), 0);

    for (int v = 0; v < NV; v++) run_seq(v);

    // R9 host request, R2 standby untouched.
    host_sw_req = 1'b1;
    negs(1);
    n = 0; other = 0;
    while (rst_main && n < 100) begin
      n++;
      host_sw_req = 1'b0;
      if (rst_sby || rst_ret) other++;
      @(negedge clk_lf);
    end
    chk("R9 host reset length", n, PULSE + 2);
    chk("R2 host leaves standby", other, 0);

    // R9 controller request, R3 main untouched.
    ctrl_sw_req = 1'b1;
    negs(1);
    n = 0; other = 0;
    while (rst_sby && n < 100) begin
      n++;
      ctrl_sw_req = 1'b0;
      if (rst_main || rst_ret) other++;
      @(negedge clk_lf);
    end
    chk("R9 ctrl reset length", n, PULSE + 2);
    chk("R3 ctrl leaves main", other, 0);

    // R9 held request does not retrigger.
    ctrl_sw_req = 1'b1;
    negs(1);
    n = 0;
    while (rst_sby && n < 100) begin
      n++;
      @(negedge clk_lf);
    end
    chk("R9 held request length", n, PULSE + 2);
    negs(10);
    chk("R9 held request no retrigger", int'(rst_sby), 0);
    ctrl_sw_req = 1'b0;

    // R10 immediate assertion from the pin, R1 retained untouched.
    #(CLK_T/4);
    hw_rst_n = 1'b0;
    #1;
    chk("R10 main asserts without edge", int'(rst_main), 1);
    negs(2);
    chk("R1 pin leaves retained", int'(rst_ret), 0);
    chk("R2 pin leaves standby", int'(rst_sby), 0);
    hw_rst_n = 1'b1;
    negs(1);
    chk("R3 main one edge after pin", int'(rst_main), 1);
    negs(1);
    chk("R3 main two edges after pin", int'(rst_main), 0);

    // R3 main supply loss.
    por_main = 1'b1;
    negs(1);
    chk("R3 main on supply loss", int'(rst_main), 1);
    chk("R2 main loss leaves standby", int'(rst_sby), 0);
    por_main = 1'b0;
    negs(3);

    // R1 retained supply loss only hits the retained domain.
    por_ret = 1'b1;
    negs(1);
    chk("R1 retained on supply loss", int'(rst_ret), 1);
    chk("R1 retained loss leaves main", int'(rst_main), 0);
    por_ret = 1'b0;
    negs(3);
    chk("R1 retained released", int'(rst_ret), 0);

    finish_run();
  end
endmodule